// File: doc/BRIEF.md
# USB Token, Start-of-Frame and Handshake Packet Transmitter

This block turns a single command into a complete low-speed/full-speed USB packet at the byte level. It drives a UTMI-style transmit port made of an 8-bit data bus, a valid strobe and a ready input. The command names a 4-bit packet identifier and, where the packet needs them, a device address and endpoint or a frame number. The block adds the complemented check nibble to the identifier byte. For three-byte packets it computes the 5-bit CRC in hardware, complements it and places it in the bit order the wire expects. The upstream logic never frames bytes itself.

The command port is a valid/ready pair. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while no packet is in flight. The transmit side follows the usual back-pressure rule. The byte on `tx_data` and the high `tx_valid` stay unchanged until a cycle in which `tx_ready` is high, and that cycle consumes the byte. `done` marks the end of each packet with a single pulse. Serialisation, NRZI coding, bit stuffing and the line driver belong to a later stage.

Top module: `usb_pkt_tx`

## Requirements
- R1: The first byte of every packet is `{~pid, pid}`: the identifier sits in bits 3:0 and its bitwise complement in bits 7:4.
- R2: Identifiers 0001 (OUT), 1001 (IN) and 1101 (SETUP) produce three bytes. Byte 1 is `{endp[0], addr[6:0]}`. Byte 2 holds `endp[3:1]` in bits 2:0 and the complemented CRC in bits 7:3, with CRC bit 4 in byte bit 3 down to CRC bit 0 in byte bit 7.
- R3: The CRC uses the polynomial x^5+x^2+1 and starts from all ones. For tokens it takes the 11 bits addr[0..6] then endp[0..3], least significant first. For start-of-frame it takes frame[0..10]. The remainder is complemented before it is placed. A SETUP to address 0, endpoint 0 is therefore 2D 00 10.
- R4: Identifier 0101 (start-of-frame) produces three bytes. Byte 1 is frame[7:0]. Byte 2 holds frame[10:8] in bits 2:0 and the complemented CRC in bits 7:3, laid out as in R2.
- R5: Identifiers 0010 (ACK), 1010 (NAK) and 1110 (STALL), and every code not named in R2 or R4, produce a single byte. ACK is D2, NAK is 5A and STALL is 1E.
- R6: `tx_valid` rises in the cycle after a command is taken, carrying byte 0. While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R7: `tx_valid` falls in the cycle after the last byte is consumed. `done` is high for exactly that one cycle.
- R8: `cmd_ready` is low while a packet is in flight. A command presented then is ignored and changes neither the current packet nor what follows it.
- R9: `busy` goes high in the cycle after a command is taken and stays high until `tx_valid` falls.
- R10: A synchronous active-high `rst` leaves `tx_valid`, `busy` and `done` low and `cmd_ready` high, even in the middle of a packet.
- R11: A command presented in the cycle where `done` is high is taken, and its first byte appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_pid | input | 4 | Packet identifier |
| cmd_addr | input | 7 | Device address for token packets |
| cmd_endp | input | 4 | Endpoint for token packets |
| cmd_frame | input | 11 | Frame number for start-of-frame packets |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte consumed this cycle |
| busy | output | 1 | Packet in flight |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
Two events can fall in the same cycle: the end-of-packet pulse and the taking of the next command, because `cmd_ready` returns in the very cycle `done` rises. The bench provokes this by presenting a NAK command at the clock where an ACK's `done` is observed. It then requires that the NAK byte appears one cycle later and that `done` has cleared. The opposite case holds a conflicting command on `cmd_valid` for a whole slowed packet. The bench drops that command in the cycle `done` is seen and confirms that no second packet follows.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;
  localparam int BYTE_W    = 8;
  localparam int PID_W     = 4;
  localparam int ADDR_W    = 7;
  localparam int ENDP_W    = 4;
  localparam int FRAME_W   = 11;
  localparam int FIELD_W   = ADDR_W + ENDP_W;
  localparam int CRC_W     = 5;
  localparam int MAX_BYTES = 3;
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int HIGH_W    = FIELD_W - BYTE_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 5'b00101;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  localparam logic [PID_W-1:0] PID_OUT   = 4'b0001;
  localparam logic [PID_W-1:0] PID_IN    = 4'b1001;
  localparam logic [PID_W-1:0] PID_SOF   = 4'b0101;
  localparam logic [PID_W-1:0] PID_SETUP = 4'b1101;

  typedef enum logic [1:0] {
    KIND_SHORT = 2'd0,
    KIND_TOKEN = 2'd1,
    KIND_FRAME = 2'd2
  } kind_e;

  typedef struct packed {
    logic [MAX_BYTES-1:0][BYTE_W-1:0] bytes;
    logic [IDX_W-1:0]                 last;
  } pkt_t;

  function automatic kind_e pid_kind(input logic [PID_W-1:0] p);
    kind_e k;
    case (p)
      PID_OUT, PID_IN, PID_SETUP: k = KIND_TOKEN;
      PID_SOF:                    k = KIND_FRAME;
      default:                    k = KIND_SHORT;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/usbtx_crc5.sv
module usbtx_crc5
  import usbtx_pkg::*;
#(
  parameter int DATA_W = FIELD_W
) (
  input  logic [DATA_W-1:0] din,
  output logic [CRC_W-1:0]  rem
);
  // Serial LFSR unrolled: bit 0 enters first.
  logic [DATA_W:0][CRC_W-1:0] stage;

  assign stage[0] = CRC_INIT;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fb;
    assign fb = din[i] ^ stage[i][CRC_W-1];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign rem = stage[DATA_W];
endmodule

// File: rtl/usbtx_frame.sv
module usbtx_frame
  import usbtx_pkg::*;
(
  input  logic [PID_W-1:0]   pid,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ENDP_W-1:0]  endp,
  input  logic [FRAME_W-1:0] frame,
  output pkt_t               pkt
);
  kind_e              kind;
  logic [FIELD_W-1:0] field;
  logic [CRC_W-1:0]   rem;
  logic [CRC_W-1:0]   chk_rev;

  assign kind  = pid_kind(pid);
  assign field = (kind == KIND_TOKEN) ? {endp, addr} : frame;

  usbtx_crc5 #(.DATA_W(FIELD_W)) i_crc (
    .din (field),
    .rem (rem)
  );

  // Complemented CRC, sent high bit first: reverse into the byte.
  for (genvar j = 0; j < CRC_W; j++) begin : g_rev
    assign chk_rev[CRC_W-1-j] = ~rem[j];
  end

  always_comb begin
    pkt.bytes[0] = {~pid, pid};
    pkt.bytes[1] = field[BYTE_W-1:0];
    pkt.bytes[2] = {chk_rev, field[FIELD_W-1:BYTE_W]};
    pkt.last     = (kind == KIND_SHORT) ? IDX_W'(0) : IDX_W'(MAX_BYTES-1);
  end
endmodule

// File: rtl/usbtx_seq.sv
module usbtx_seq
  import usbtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  pkt_t              pkt_in,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              busy,
  output logic              done
);
  pkt_t             pkt_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic             done_q;
  logic             take;
  logic             last_go;

  assign take    = cmd_valid && !valid_q;
  assign last_go = valid_q && tx_ready && (idx_q == pkt_q.last);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      pkt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        pkt_q   <= pkt_in;
        idx_q   <= '0;
        valid_q <= 1'b1;
      end else if (valid_q && tx_ready) begin
        if (last_go) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign cmd_ready = !valid_q;
  assign tx_valid  = valid_q;
  assign tx_data   = pkt_q.bytes[idx_q];
  assign busy      = valid_q;
  assign done      = done_q;

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r7_done_end: assert property (@(posedge clk) disable iff (rst)
    done |-> !tx_valid && $past(tx_valid && tx_ready));

  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    busy && cmd_valid && !tx_ready |=> busy && $stable(tx_data));

  a_r9_start: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> busy && tx_valid && !done);

  a_r10_reset: assert property (@(posedge clk)
    rst |=> !tx_valid && !busy && !done);
endmodule

// File: rtl/usb_pkt_tx.sv
module usb_pkt_tx
  import usbtx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [PID_W-1:0]   cmd_pid,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [ENDP_W-1:0]  cmd_endp,
  input  logic [FRAME_W-1:0] cmd_frame,
  output logic [BYTE_W-1:0]  tx_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic               busy,
  output logic               done
);
  pkt_t built;

  usbtx_frame i_frame (
    .pid   (cmd_pid),
    .addr  (cmd_addr),
    .endp  (cmd_endp),
    .frame (cmd_frame),
    .pkt   (built)
  );

  usbtx_seq i_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .pkt_in    (built),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .busy      (busy),
    .done      (done)
  );

  a_r1_pid_check: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_data[7:4] == ~tx_data[3:0]);

  a_r11_chain: assert property (@(posedge clk) disable iff (rst)
    done && cmd_valid |=> tx_valid && tx_data[3:0] == $past(cmd_pid));
endmodule

// File: tb/test_usb_pkt_tx.sv
module test_usb_pkt_tx;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_pid = '0;
  logic [6:0]  cmd_addr = '0;
  logic [3:0]  cmd_endp = '0;
  logic [10:0] cmd_frame = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic        busy;
  logic        done;

  int total = 0;
  int bad = 0;
  logic [7:0] got [8];
  int got_n;

  always #2 clk = ~clk;

  usb_pkt_tx i_usb_pkt_tx (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_pid(cmd_pid), .cmd_addr(cmd_addr), .cmd_endp(cmd_endp),
    .cmd_frame(cmd_frame), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void expect_pkt(input logic [3:0] p, input logic [6:0] a,
                                     input logic [3:0] e, input logic [10:0] f,
                                     output int n, output logic [7:0] x0,
                                     output logic [7:0] x1, output logic [7:0] x2);
    logic [10:0] fld;
    logic [4:0]  c;
    logic        fb;
    bit tok, sof;
    tok = (p == 4'h1) || (p == 4'h9) || (p == 4'hD);
    sof = (p == 4'h5);
    fld = tok ? {e, a} : f;
    c = 5'h1F;
    for (int i = 0; i < 11; i++) begin
      fb = fld[i] ^ c[4];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'h05;
    end
    x0 = {~p, p};
    x1 = fld[7:0];
    x2[2:0] = fld[10:8];
    for (int j = 0; j < 5; j++) x2[7-j] = ~c[j];
    n = (tok || sof) ? 3 : 1;
  endfunction

  task automatic issue(input logic [3:0] p, input logic [6:0] a,
                       input logic [3:0] e, input logic [10:0] f);
    cmd_pid = p; cmd_addr = a; cmd_endp = e; cmd_frame = f;
    cmd_valid = 1'b1;
    chk(cmd_ready === 1'b1, "R8 cmd_ready when idle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic collect(input int mode);
    int k;
    logic pv, pr, rdy;
    logic [7:0] pd;
    got_n = 0; k = 0; pv = 1'b0; pr = 1'b0; pd = '0;
    chk(tx_valid === 1'b1, "R6 tx_valid after accept", tx_valid, 1);
    chk(busy === 1'b1, "R9 busy after accept", busy, 1);
    while (tx_valid === 1'b1 && k < 300) begin
      if (pv && !pr) chk(tx_data === pd, "R6 data held", tx_data, pd);
      chk(busy === 1'b1 && cmd_ready === 1'b0, "R9 busy in flight", busy, 1);
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? (k % 2 == 1) : (k % 3 == 2);
      tx_ready = rdy;
      if (rdy && got_n < 8) begin
        got[got_n] = tx_data;
        got_n++;
      end
      pv = 1'b1; pr = rdy; pd = tx_data;
      @(negedge clk);
      k++;
    end
    tx_ready = 1'b0;
    chk(tx_valid === 1'b0, "R7 tx_valid falls", tx_valid, 0);
    chk(done === 1'b1, "R7 done pulse", done, 1);
    chk(busy === 1'b0, "R9 busy cleared", busy, 0);
  endtask

  task automatic compare(input logic [3:0] p, input logic [6:0] a,
                         input logic [3:0] e, input logic [10:0] f, input string req);
    int n;
    logic [7:0] x [3];
    expect_pkt(p, a, e, f, n, x[0], x[1], x[2]);
    chk(got_n == n, {req, " length"}, got_n, n);
    for (int i = 0; i < n && i < got_n; i++)
      chk(got[i] === x[i], {req, " byte"}, got[i], x[i]);
  endtask

  task automatic send_pkt(input logic [3:0] p, input logic [6:0] a,
                          input logic [3:0] e, input logic [10:0] f,
                          input int mode, input string req);
    issue(p, a, e, f);
    collect(mode);
    compare(p, a, e, f, req);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", done, 0);
  endtask

  task automatic t_reset();
    chk(tx_valid === 1'b0, "R10 tx_valid in reset", tx_valid, 0);
    chk(busy === 1'b0, "R10 busy in reset", busy, 0);
    chk(done === 1'b0, "R10 done in reset", done, 0);
    chk(cmd_ready === 1'b1, "R10 cmd_ready in reset", cmd_ready, 1);
  endtask

  task automatic t_handshake();
    send_pkt(4'h2, 7'h00, 4'h0, 11'h0, 0, "R5 ACK");
    chk(got[0] === 8'hD2, "R5 ACK is D2", got[0], 8'hD2);
    send_pkt(4'hA, 7'h11, 4'h2, 11'h0, 1, "R5 NAK");
    chk(got[0] === 8'h5A, "R5 NAK is 5A", got[0], 8'h5A);
    send_pkt(4'hE, 7'h7F, 4'hF, 11'h7FF, 2, "R5 STALL");
    chk(got[0] === 8'h1E, "R5 STALL is 1E", got[0], 8'h1E);
    send_pkt(4'h3, 7'h01, 4'h1, 11'h1, 0, "R5 other code one byte");
    chk(got[0] === 8'hC3, "R1 pid byte other code", got[0], 8'hC3);
  endtask

  task automatic t_tokens();
    send_pkt(4'hD, 7'h00, 4'h0, 11'h0, 0, "R3 SETUP 0/0");
    chk(got[0] === 8'h2D && got[1] === 8'h00 && got[2] === 8'h10,
        "R3 SETUP zero anchor", {got[0], got[1], got[2]}, 24'h2D0010);
    send_pkt(4'h1, 7'h12, 4'h0, 11'h0, 0, "R2 OUT");
    send_pkt(4'h9, 7'h12, 4'h1, 11'h0, 1, "R2 IN");
    send_pkt(4'h1, 7'h7F, 4'hF, 11'h0, 2, "R2 OUT all ones");
    send_pkt(4'h9, 7'h55, 4'hA, 11'h3AB, 0, "R2 IN frame ignored");
    chk(got[0] === 8'h69, "R1 IN pid byte", got[0], 8'h69);
  endtask

  task automatic t_sof();
    send_pkt(4'h5, 7'h00, 4'h0, 11'h000, 0, "R4 SOF zero");
    send_pkt(4'h5, 7'h7F, 4'hF, 11'h7FF, 1, "R4 SOF max");
    send_pkt(4'h5, 7'h12, 4'h3, 11'h123, 2, "R4 SOF mid");
    chk(got[1] === 8'h23, "R4 frame low byte", got[1], 8'h23);
  endtask

  task automatic t_busy_ignore();
    issue(4'hD, 7'h05, 4'h3, 11'h0);
    cmd_pid = 4'h2; cmd_addr = 7'h44; cmd_endp = 4'h9; cmd_valid = 1'b1;
    collect(1);
    cmd_valid = 1'b0;
    compare(4'hD, 7'h05, 4'h3, 11'h0, "R8 packet unchanged");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(tx_valid === 1'b0, "R8 no stale packet", tx_valid, 0);
    end
  endtask

  task automatic t_back_to_back();
    issue(4'h2, 7'h0, 4'h0, 11'h0);
    collect(0);
    compare(4'h2, 7'h0, 4'h0, 11'h0, "R11 first");
    chk(cmd_ready === 1'b1, "R11 ready with done", cmd_ready, 1);
    issue(4'hA, 7'h0, 4'h0, 11'h0);
    chk(done === 1'b0, "R11 done cleared", done, 0);
    chk(tx_valid === 1'b1 && tx_data === 8'h5A, "R11 next packet starts", tx_data, 8'h5A);
    collect(0);
    compare(4'hA, 7'h0, 4'h0, 11'h0, "R11 second");
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    issue(4'h5, 7'h0, 4'h0, 11'h2AA);
    tx_ready = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    chk(tx_valid === 1'b0, "R10 stays idle", tx_valid, 0);
    send_pkt(4'h2, 7'h0, 4'h0, 11'h0, 0, "R10 ACK after reset");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_handshake();
    t_tokens();
    t_sof();
    t_busy_ignore();
    t_back_to_back();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule